// File: doc/BRIEF.md
# Command-Response Buffer Register Target

This block is the device side of a command-response buffer interface, reached by a host over a simple 32-bit register bus. The host claims locality 0, asks the device to leave or enter its low-power idle state, fills a data window with a command, and starts it. The host then polls until the start flag drops. At that point the response is waiting in the same window. The host can abort a running command through a cancel flag, which it holds until it clears the flag itself.

Command execution is not real. A behavioural stand-in holds the start flag for a fixed number of cycles and then clears it. Power-state requests are set-only bits that clear themselves after a parameterised latency. The idle flag follows whichever request completed last. A start issued at the wrong moment is dropped and raises an error flag, and the next completed ready request clears that flag.

A bus access is accepted in the cycle `req_valid_i` is high. A read returns its data one cycle later, with `rsp_valid_o` high and the register value as it stood at the accepting edge.

Top module: `crb_target`

## Requirements
- R1: After reset the registers read: locality state 0x80, locality status 0, control request 0, control status 0x2 (idle set, error clear), start 0, cancel 0, interrupt enable 0, interrupt status 0, and interface ID 0x1.
- R2: Writing 1 to bit 0 of locality control (0x08) assigns locality 0. Locality state (0x00) then reads 0x83, with bit 7 valid, bit 1 assigned and bit 0 established, and locality status (0x0C) bit 0 reads 1.
- R3: Writing bit 1 of locality control releases the locality, and relinquish wins when both bits are written together. Locality state then reads 0x81, because established is sticky, and locality status reads 0.
- R4: Writing bit 0 of control request (0x40) asks for ready. The bit reads 1 until PWR_LAT cycles have passed and then reads 0. On completion, control status idle (bit 1) and error (bit 0) both clear.
- R5: Writing bit 1 of control request asks for idle. It self-clears after PWR_LAT cycles and sets control status bit 1. When both bits are written at once, ready completes first and idle completes PWR_LAT cycles later, so the block ends idle.
- R6: Control request bits are set-only: writing 0 to a pending bit leaves it pending.
- R7: Writing 1 to start (0x4C) while the locality is assigned, the block is not idle and no command is running makes start read 1 for EXEC_CYCLES cycles, after which it reads 0.
- R8: A start written while idle or unassigned is ignored. Start stays 0 and control status bit 0 (error) is set.
- R9: Writing 1 to cancel (0x48) while a command runs clears start on the next cycle. Cancel reads back 1 until the host writes 0.
- R10: In interrupt enable (0x50) only bit 31 is storable. Interrupt status (0x54) always reads 0 and ignores writes.
- R11: Command and response address low registers (0x5C, 0x68) read 0x80, the high registers (0x60, 0x6C) read 0, and both size registers (0x58, 0x64) read BUF_WORDS*4.
- R12: The data window from 0x80 holds BUF_WORDS 32-bit words, one word per aligned address. A word written there reads back unchanged, including the last word.
- R13: Reads of unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus access valid this cycle |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |

## Verification
The bench targets the start rules. It issues a start while idle and unassigned, a start while assigned but still idle, and a start after the locality is released but while the block is ready. A design that skipped either condition would show start at 1 or leave the error bit clear. Cancel is checked mid-command, well before the execution count ends, so a design that ignored cancel would still show start at 1. The bench also writes 0 over a pending ready request, which catches a request register that is plainly writable. It requests both power states together and reads the intermediate value, which shows whether ready is ordered ahead of idle. Relinquish is written together with request, so a design that gave request priority would read assigned.

// File: rtl/crb_pkg.sv
package crb_pkg;

  localparam int OFF_LOC_STATE = 'h00;
  localparam int OFF_LOC_CTRL  = 'h08;
  localparam int OFF_LOC_STS   = 'h0C;
  localparam int OFF_INTF_ID   = 'h30;
  localparam int OFF_CTRL_REQ  = 'h40;
  localparam int OFF_CTRL_STS  = 'h44;
  localparam int OFF_CANCEL    = 'h48;
  localparam int OFF_START     = 'h4C;
  localparam int OFF_INT_EN    = 'h50;
  localparam int OFF_INT_STS   = 'h54;
  localparam int OFF_CMD_SIZE  = 'h58;
  localparam int OFF_CMD_LO    = 'h5C;
  localparam int OFF_CMD_HI    = 'h60;
  localparam int OFF_RSP_SIZE  = 'h64;
  localparam int OFF_RSP_LO    = 'h68;
  localparam int OFF_RSP_HI    = 'h6C;
  localparam int BUF_BASE      = 'h80;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_LOC_STATE, SEL_LOC_CTRL, SEL_LOC_STS, SEL_INTF_ID,
    SEL_CTRL_REQ, SEL_CTRL_STS, SEL_CANCEL, SEL_START, SEL_INT_EN,
    SEL_INT_STS, SEL_CMD_SIZE, SEL_CMD_LO, SEL_CMD_HI, SEL_RSP_SIZE,
    SEL_RSP_LO, SEL_RSP_HI
  } crb_sel_e;

  function automatic crb_sel_e crb_decode(input logic [31:0] a);
    case (a)
      OFF_LOC_STATE: return SEL_LOC_STATE;
      OFF_LOC_CTRL:  return SEL_LOC_CTRL;
      OFF_LOC_STS:   return SEL_LOC_STS;
      OFF_INTF_ID:   return SEL_INTF_ID;
      OFF_CTRL_REQ:  return SEL_CTRL_REQ;
      OFF_CTRL_STS:  return SEL_CTRL_STS;
      OFF_CANCEL:    return SEL_CANCEL;
      OFF_START:     return SEL_START;
      OFF_INT_EN:    return SEL_INT_EN;
      OFF_INT_STS:   return SEL_INT_STS;
      OFF_CMD_SIZE:  return SEL_CMD_SIZE;
      OFF_CMD_LO:    return SEL_CMD_LO;
      OFF_CMD_HI:    return SEL_CMD_HI;
      OFF_RSP_SIZE:  return SEL_RSP_SIZE;
      OFF_RSP_LO:    return SEL_RSP_LO;
      OFF_RSP_HI:    return SEL_RSP_HI;
      default:       return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/crb_locality.sv
module crb_locality (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       rel_i,
  output logic       assigned_o,
  output logic [7:0] state_o
);
  logic assigned_q, estb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      assigned_q <= 1'b0;
      estb_q     <= 1'b0;
    end else begin
      if (rel_i)      assigned_q <= 1'b0;
      else if (req_i) assigned_q <= 1'b1;
      if (req_i && !rel_i) estb_q <= 1'b1;
    end
  end

  assign assigned_o = assigned_q;
  assign state_o    = {1'b1, 5'b0, assigned_q, estb_q};

  AST_GRANT_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !rel_i |=> assigned_o && state_o[0]); // R2
  AST_RELINQ_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |=> !assigned_o); // R3
endmodule

// File: rtl/crb_power.sv
module crb_power #(
  parameter int PWR_LAT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_ready_i,
  input  logic       go_idle_i,
  output logic [1:0] req_o,
  output logic       idle_o,
  output logic       ready_done_o
);
  localparam int CW = $clog2(PWR_LAT + 1);
  localparam logic [CW-1:0] LOAD = CW'(PWR_LAT);

  logic          rdy_q, idl_q, idle_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fire, done_rdy, done_idl, rdy_d, idl_d;

  assign fire     = (cnt_q == CW'(1));
  assign done_rdy = fire && rdy_q;
  assign done_idl = fire && !rdy_q && idl_q;  // ready is served first

  always_comb begin
    rdy_d = (rdy_q && !done_rdy) || go_ready_i;
    idl_d = (idl_q && !done_idl) || go_idle_i;
    if (cnt_q > CW'(1))      cnt_d = cnt_q - CW'(1);
    else if (rdy_d || idl_d) cnt_d = LOAD;
    else                     cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      idl_q  <= 1'b0;
      idle_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      rdy_q <= rdy_d;
      idl_q <= idl_d;
      cnt_q <= cnt_d;
      if (done_rdy)      idle_q <= 1'b0;
      else if (done_idl) idle_q <= 1'b1;
    end
  end

  assign req_o        = {idl_q, rdy_q};
  assign idle_o       = idle_q;
  assign ready_done_o = done_rdy;

  AST_READY_LEAVES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o[0]) |-> !idle_o); // R4
  AST_IDLE_ENTERS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o[1]) |-> idle_o); // R5
  AST_REQ_HELD_ON_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_ready_i |=> req_o[0]); // R6
endmodule

// File: rtl/crb_exec.sv
module crb_exec #(
  parameter int EXEC_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_wr_i,
  input  logic cancel_wr_i,
  input  logic cancel_val_i,
  input  logic assigned_i,
  input  logic idle_i,
  input  logic ready_done_i,
  output logic start_o,
  output logic cancel_o,
  output logic err_o
);
  localparam int CW = $clog2(EXEC_CYCLES + 1);

  logic          start_q, cancel_q, err_q;
  logic [CW-1:0] cnt_q;
  logic          accept, reject;

  assign accept = start_wr_i && assigned_i && !idle_i && !start_q;
  assign reject = start_wr_i && (!assigned_i || idle_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      cancel_q <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (cancel_wr_i) cancel_q <= cancel_val_i;
      if (accept) begin
        start_q <= 1'b1;
        cnt_q   <= CW'(EXEC_CYCLES);
      end else if (start_q) begin
        if (cancel_q || cnt_q == CW'(1)) begin
          start_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
      if (reject)            err_q <= 1'b1;
      else if (ready_done_i) err_q <= 1'b0;
    end
  end

  assign start_o  = start_q;
  assign cancel_o = cancel_q;
  assign err_o    = err_q;

  AST_START_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(assigned_i && !idle_i)); // R7
  AST_BAD_START_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(idle_i || !assigned_i)); // R8
  AST_CANCEL_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && cancel_o |=> !start_o); // R9
  AST_ERR_CLEARS_ON_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(ready_done_i)); // R4
endmodule

// File: rtl/crb_buffer.sv
module crb_buffer #(
  parameter int WORDS = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic [31:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (wr_i && idx_i == IDX_W'(g))     mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = (int'(idx_i) < WORDS) ? mem_q[idx_i] : '0;
endmodule

// File: rtl/crb_target.sv
module crb_target #(
  parameter int ADDR_W      = 8,
  parameter int BUF_WORDS   = 16,
  parameter int PWR_LAT     = 4,
  parameter int EXEC_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o
);
  import crb_pkg::*;

  localparam int BUF_BYTES = BUF_WORDS * 4;
  localparam int IDX_W     = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  logic [31:0] a32;
  crb_sel_e    sel;
  logic        wr, rd, buf_hit;
  logic [IDX_W-1:0] buf_idx;
  logic [31:0] buf_rdata, rd_mux, off;

  assign a32     = 32'(req_addr_i);
  assign sel     = crb_decode(a32);
  assign wr      = req_valid_i && req_write_i;
  assign rd      = req_valid_i && !req_write_i;
  assign buf_hit = (a32 >= 32'(BUF_BASE)) && (a32 < 32'(BUF_BASE + BUF_BYTES));
  assign off     = a32 - 32'(BUF_BASE);
  assign buf_idx = IDX_W'(off >> 2);

  logic       assigned;
  logic [7:0] loc_state;
  logic [1:0] pwr_req;
  logic       idle, ready_done, start, cancel, err;
  logic       int_en_q;

  crb_locality u_loc (
    .clk_i, .rst_ni,
    .req_i     (wr && sel == SEL_LOC_CTRL && req_wdata_i[0]),
    .rel_i     (wr && sel == SEL_LOC_CTRL && req_wdata_i[1]),
    .assigned_o(assigned),
    .state_o   (loc_state)
  );

  crb_power #(.PWR_LAT(PWR_LAT)) u_pwr (
    .clk_i, .rst_ni,
    .go_ready_i  (wr && sel == SEL_CTRL_REQ && req_wdata_i[0]),
    .go_idle_i   (wr && sel == SEL_CTRL_REQ && req_wdata_i[1]),
    .req_o       (pwr_req),
    .idle_o      (idle),
    .ready_done_o(ready_done)
  );

  crb_exec #(.EXEC_CYCLES(EXEC_CYCLES)) u_exec (
    .clk_i, .rst_ni,
    .start_wr_i  (wr && sel == SEL_START && req_wdata_i[0]),
    .cancel_wr_i (wr && sel == SEL_CANCEL),
    .cancel_val_i(req_wdata_i[0]),
    .assigned_i  (assigned),
    .idle_i      (idle),
    .ready_done_i(ready_done),
    .start_o     (start),
    .cancel_o    (cancel),
    .err_o       (err)
  );

  crb_buffer #(.WORDS(BUF_WORDS), .IDX_W(IDX_W)) u_buf (
    .clk_i, .rst_ni,
    .wr_i   (wr && buf_hit),
    .idx_i  (buf_idx),
    .wdata_i(req_wdata_i),
    .rdata_o(buf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       int_en_q <= 1'b0;
    else if (wr && sel == SEL_INT_EN)  int_en_q <= req_wdata_i[31];
  end

  always_comb begin
    unique case (sel)
      SEL_LOC_STATE: rd_mux = {24'b0, loc_state};
      SEL_LOC_STS:   rd_mux = {31'b0, assigned};
      SEL_INTF_ID:   rd_mux = 32'h1;
      SEL_CTRL_REQ:  rd_mux = {30'b0, pwr_req};
      SEL_CTRL_STS:  rd_mux = {30'b0, idle, err};
      SEL_CANCEL:    rd_mux = {31'b0, cancel};
      SEL_START:     rd_mux = {31'b0, start};
      SEL_INT_EN:    rd_mux = {int_en_q, 31'b0};
      SEL_CMD_SIZE,
      SEL_RSP_SIZE:  rd_mux = 32'(BUF_BYTES);
      SEL_CMD_LO,
      SEL_RSP_LO:    rd_mux = 32'(BUF_BASE);
      default:       rd_mux = buf_hit ? buf_rdata : 32'h0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd;
      if (rd) rsp_rdata_o <= rd_mux;
    end
  end

  AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(rd)); // R13
  AST_START_NOT_WHILE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start) |-> !idle); // R8
endmodule

// File: tb/crb_target_bench.sv
module crb_target_bench;
  localparam int ADDR_W = 8, BUF_WORDS = 16, PWR_LAT = 4, EXEC_CYCLES = 8;

  logic clk_i = 0, rst_ni = 0;
  logic req_valid_i = 0, req_write_i = 0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic rsp_valid_o;
  logic [31:0] rsp_rdata_o;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #4 clk_i = ~clk_i;

  crb_target #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS), .PWR_LAT(PWR_LAT),
               .EXEC_CYCLES(EXEC_CYCLES)) u_crb_target (.*);

  task automatic wr(input int a, input logic [31:0] d);
    req_valid_i = 1; req_write_i = 1; req_addr_i = ADDR_W'(a); req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    req_valid_i = 1; req_write_i = 0; req_addr_i = ADDR_W'(a);
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: pops expected items as responses arrive
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected response got=%h exp=none", rsp_rdata_o);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rsp_rdata_o !== e) begin
          errors++;
          $display("FAIL %s got=%h exp=%h", t, rsp_rdata_o, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    rd('h00, 32'h80, "R1 loc state");
    rd('h0C, 0, "R1 loc status");
    rd('h40, 0, "R1 ctrl req");
    rd('h44, 32'h2, "R1 ctrl status");
    rd('h4C, 0, "R1 start");
    rd('h48, 0, "R1 cancel");
    rd('h50, 0, "R1 int enable");
    rd('h54, 0, "R1 int status");
    rd('h30, 32'h1, "R1 interface id");
    // R11 address and size
    rd('h58, BUF_WORDS*4, "R11 cmd size");
    rd('h64, BUF_WORDS*4, "R11 rsp size");
    rd('h5C, 32'h80, "R11 cmd addr lo");
    rd('h60, 0, "R11 cmd addr hi");
    rd('h68, 32'h80, "R11 rsp addr lo");
    rd('h6C, 0, "R11 rsp addr hi");
    // R8 start while idle and unassigned
    wr('h4C, 1);
    rd('h4C, 0, "R8 start ignored idle+unassigned");
    rd('h44, 32'h3, "R8 error set");
    // R2 locality request
    wr('h08, 1);
    rd('h00, 32'h83, "R2 loc state granted");
    rd('h0C, 1, "R2 loc status");
    // R8 assigned but idle
    wr('h4C, 1);
    rd('h4C, 0, "R8 start ignored while idle");
    // R4 go ready
    wr('h40, 1);
    rd('h40, 1, "R4 ready pending");
    idle_cycles(PWR_LAT + 2);
    rd('h40, 0, "R4 ready self-clear");
    rd('h44, 0, "R4 idle and error clear");
    // R6 set-only
    wr('h40, 1);
    wr('h40, 0);
    rd('h40, 1, "R6 write 0 leaves pending");
    idle_cycles(PWR_LAT + 2);
    rd('h40, 0, "R6 completes");
    // R12 buffer
    for (int i = 0; i < 4; i++) wr('h80 + 4*i, 32'hA5000000 + 32'(i * 'h1111));
    wr('h80 + 4*(BUF_WORDS-1), 32'hDEADBEEF);
    for (int i = 0; i < 4; i++) rd('h80 + 4*i, 32'hA5000000 + 32'(i * 'h1111), "R12 buffer word");
    rd('h80 + 4*(BUF_WORDS-1), 32'hDEADBEEF, "R12 last word");
    // R7 accepted start
    wr('h4C, 1);
    rd('h4C, 1, "R7 start running");
    idle_cycles(EXEC_CYCLES + 2);
    rd('h4C, 0, "R7 start cleared on completion");
    rd('h44, 0, "R7 no error");
    rd('h80, 32'hA5000000, "R12 response shares buffer");
    // R9 cancel
    wr('h4C, 1);
    wr('h48, 1);
    idle_cycles(1);
    rd('h4C, 0, "R9 cancel aborts start");
    rd('h48, 1, "R9 cancel held");
    wr('h48, 0);
    rd('h48, 0, "R9 cancel removed");
    // R10 interrupts
    wr('h50, 32'hFFFFFFFF);
    rd('h50, 32'h80000000, "R10 int enable bit31 only");
    wr('h54, 32'hFFFFFFFF);
    rd('h54, 0, "R10 int status reads 0");
    // R13 unmapped
    wr('h20, 32'h12345678);
    rd('h20, 0, "R13 unmapped write ignored");
    rd('h74, 0, "R13 unmapped read");
    // R5 both requests: ready first then idle
    wr('h40, 3);
    idle_cycles(PWR_LAT + 1);
    rd('h40, 32'h2, "R5 ready done, idle pending");
    rd('h44, 0, "R5 not idle yet");
    idle_cycles(PWR_LAT);
    rd('h40, 0, "R5 both done");
    rd('h44, 32'h2, "R5 ends idle");
    // R3 relinquish, both bits -> relinquish wins
    wr('h08, 2);
    rd('h00, 32'h81, "R3 released, established sticky");
    rd('h0C, 0, "R3 loc status");
    wr('h08, 3);
    rd('h00, 32'h81, "R3 relinquish wins");
    // R8 unassigned but ready
    wr('h40, 1);
    idle_cycles(PWR_LAT + 2);
    rd('h44, 0, "R4 ready again");
    wr('h4C, 1);
    rd('h4C, 0, "R8 start ignored unassigned");
    rd('h44, 32'h1, "R8 error unassigned");
    idle_cycles(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R13 missing responses got=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule